// File: doc/BRIEF.md
# Log-Depth Lookahead Binary Adder

This block adds two unsigned WIDTH-bit operands and a single carry-in bit, and returns a WIDTH-bit sum and a carry-out. It is purely combinational, with no clock, no storage and no handshake. A caller drives the operands and reads the result in the same cycle.

Each bit position first forms a propagate flag (the operand bits differ) and a generate flag (both operand bits are one). A balanced binary tree of two-input merge cells combines neighbouring spans into span-level propagate and generate flags, working up to the root. A second pass works back down the same tree. The carry entering a span's lower half is the span's own carry-in. The carry entering its upper half is the lower half's generate, ORed with the lower half's propagate ANDed with the span's carry-in. Each sum bit is the bit's propagate XORed with the carry that reaches it. The carry-out is the root generate ORed with the root propagate ANDed with the carry-in. Because of this structure, the depth of the carry logic grows with log2(WIDTH) and not with WIDTH.

Top module: `cla_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, {carry_out, sum_o} equals op_a + op_b + carry_in, taken as a (WIDTH+1)-bit unsigned value.
- R2: carry_in has weight one. With both operands zero and carry_in = 1, sum_o is 1 and carry_out is 0.
- R3: When op_a is all ones, op_b is zero and carry_in is 1, sum_o is zero and carry_out is 1.
- R4: Each sum bit i equals (op_a[i] XOR op_b[i]) XOR the carry entering bit i. The carry entering bit 0 is carry_in.
- R5: The carry entering bit i+1 equals g_i OR (p_i AND the carry entering bit i), where p_i is op_a[i] XOR op_b[i] and g_i is op_a[i] AND op_b[i].
- R6: When every bit propagates (op_a = ~op_b), the result is all ones with carry_out 0 for carry_in = 0. It is zero with carry_out 1 for carry_in = 1.
- R7: A generate in the top bit alone (both operand MSBs set, all other bits zero, carry_in 0) gives sum_o zero and carry_out 1.
- R8: WIDTH must be a power of two of at least 2, and the same structure computes R1 correctly at WIDTH = 32.
- R9: The outputs settle within the same cycle as the inputs change. A result sampled half a clock period after the inputs change already matches R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong merge cell or a wrong carry-distribution node corrupts the carry of every bit position in the upper half of that span. It therefore shows up as a sum error at the first operand pair whose lower half generates or propagates across that boundary. Since the block is combinational, the fault appears in the same cycle as the offending inputs. At 8 bits every operand pair and both carry-in values are applied, so any such fault is exposed. At 32 bits, random operands are mixed with long propagate runs to reach the deep tree nodes.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Merge two adjacent spans: lower span (g_lo, p_lo), upper span (g_hi, p_hi).
  function automatic logic span_gen(input logic g_lo, input logic p_hi, input logic g_hi);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic span_prop(input logic p_lo, input logic p_hi);
    return p_lo & p_hi;
  endfunction

  // Carry leaving a span given the carry entering it.
  function automatic logic carry_across(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell (
  input  logic x,
  input  logic y,
  output logic prop,
  output logic gen
);
  assign prop = x ^ y;
  assign gen  = x & y;
endmodule

// File: rtl/cla_merge_cell.sv
module cla_merge_cell
  import cla_pkg::*;
(
  input  logic p_lo,
  input  logic g_lo,
  input  logic p_hi,
  input  logic g_hi,
  input  logic c_in,
  output logic p_out,
  output logic g_out,
  output logic c_lo,
  output logic c_hi
);
  // Upward: span flags.
  assign p_out = span_prop(p_lo, p_hi);
  assign g_out = span_gen(g_lo, p_hi, g_hi);
  // Downward: carries into each half.
  assign c_lo  = c_in;
  assign c_hi  = carry_across(g_lo, p_lo, c_in);
endmodule

// File: rtl/cla_tree.sv
module cla_tree #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] leaf_p,
  input  logic [WIDTH-1:0] leaf_g,
  input  logic             c_root,
  output logic [WIDTH-1:0] leaf_c,
  output logic             root_p,
  output logic             root_g
);
  // Heap numbering: node 1 is the root, node n has children 2n (lower
  // half) and 2n+1 (upper half), leaf for bit i is node WIDTH+i.
  localparam int unsigned NODES = 2 * WIDTH;

  logic [NODES-1:1] node_p;
  logic [NODES-1:1] node_g;
  logic [NODES-1:1] node_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    assign node_p[WIDTH+i] = leaf_p[i];
    assign node_g[WIDTH+i] = leaf_g[i];
    assign leaf_c[i]       = node_c[WIDTH+i];
  end

  assign node_c[1] = c_root;

  for (genvar n = 1; n < WIDTH; n++) begin : g_node
    cla_merge_cell u_merge (
      .p_lo  (node_p[2*n]),
      .g_lo  (node_g[2*n]),
      .p_hi  (node_p[2*n+1]),
      .g_hi  (node_g[2*n+1]),
      .c_in  (node_c[n]),
      .p_out (node_p[n]),
      .g_out (node_g[n]),
      .c_lo  (node_c[2*n]),
      .c_hi  (node_c[2*n+1])
    );
  end

  assign root_p = node_p[1];
  assign root_g = node_g[1];
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  localparam int unsigned LEVELS = $clog2(WIDTH);

  if (!is_pow2(WIDTH) || ((1 << LEVELS) != WIDTH)) begin : g_bad_width
    $error("cla_adder: WIDTH must be a power of two of at least 2");
  end

  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_c;
  logic             grp_p;
  logic             grp_g;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    cla_pg_cell u_pg (
      .x    (op_a[i]),
      .y    (op_b[i]),
      .prop (bit_p[i]),
      .gen  (bit_g[i])
    );
    assign sum_o[i] = bit_p[i] ^ bit_c[i];
  end

  cla_tree #(.WIDTH(WIDTH)) u_tree (
    .leaf_p (bit_p),
    .leaf_g (bit_g),
    .c_root (carry_in),
    .leaf_c (bit_c),
    .root_p (grp_p),
    .root_g (grp_g)
  );

  assign carry_out = carry_across(grp_g, grp_p, carry_in);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_out,
  input logic [WIDTH-1:0] bit_c
);
  logic [WIDTH:0] ref_total;
  logic [WIDTH:0] carry_chain;

  always_comb begin
    ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    carry_chain = {carry_out, bit_c};
    // R1
    arith_total_chk: assert ({carry_out, sum_o} == ref_total)
      else $error("R1 sum mismatch");
    // R4
    bit0_carry_chk: assert (bit_c[0] == carry_in)
      else $error("R4 bit 0 carry differs from carry_in");
    for (int i = 0; i < WIDTH; i++) begin
      // R4
      sum_bit_chk: assert (sum_o[i] == (op_a[i] ^ op_b[i] ^ bit_c[i]))
        else $error("R4 sum bit %0d", i);
      // R5
      local_carry_chk: assert (carry_chain[i+1] ==
                               ((op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & carry_chain[i])))
        else $error("R5 carry into bit %0d", i + 1);
    end
    // R6
    full_prop_chk: assert (!((op_a ^ op_b) == {WIDTH{1'b1}}) || (carry_out == carry_in))
      else $error("R6 full propagate carry_out");
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_o     (sum_o),
  .carry_out (carry_out),
  .bit_c     (bit_c)
);

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W8 = 8;
  localparam int W32 = 32;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W8-1:0]  a8, b8, s8;
  logic           ci8, co8;
  logic [W32-1:0] a32, b32, s32;
  logic           ci32, co32;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  cla_adder #(.WIDTH(W8)) dut (
    .op_a(a8), .op_b(b8), .carry_in(ci8), .sum_o(s8), .carry_out(co8)
  );
  cla_adder #(.WIDTH(W32)) dut32 (
    .op_a(a32), .op_b(b32), .carry_in(ci32), .sum_o(s32), .carry_out(co32)
  );

  task automatic chk(input string req, input logic [W32:0] got, input logic [W32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic c);
    @(posedge clk);
    a8 <= a; b8 <= b; ci8 <= c;
    @(negedge clk);
  endtask

  task automatic apply32(input logic [W32-1:0] a, input logic [W32-1:0] b, input logic c);
    @(posedge clk);
    a32 <= a; b32 <= b; ci32 <= c;
    @(negedge clk);
    chk("R8", {co32, s32}, {1'b0, a} + {1'b0, b} + {32'd0, c});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    @(negedge clk);
    // Quiescent state with zero inputs (R1).
    chk("R1 zero", {24'd0, co8, s8}, '0);
    // R2: carry-in has weight one.
    apply8(8'h00, 8'h00, 1'b1);
    chk("R2", {24'd0, co8, s8}, 33'd1);
    // R3: all ones plus carry-in wraps to zero.
    apply8(8'hFF, 8'h00, 1'b1);
    chk("R3", {24'd0, co8, s8}, 33'h100);
    // R6: full propagate, both carry-in values.
    apply8(8'h55, 8'hAA, 1'b0);
    chk("R6 cin0", {24'd0, co8, s8}, 33'h0FF);
    apply8(8'h55, 8'hAA, 1'b1);
    chk("R6 cin1", {24'd0, co8, s8}, 33'h100);
    // R7: generate in MSB only.
    apply8(8'h80, 8'h80, 1'b0);
    chk("R7", {24'd0, co8, s8}, 33'h100);
    // R9: changed inputs already settled half a period later.
    apply8(8'h0F, 8'h01, 1'b0);
    chk("R9", {24'd0, co8, s8}, 33'h010);
    // R1 / R4 / R5: exhaustive at 8 bits.
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply8(x[7:0], y[7:0], c[0]);
          chk("R1", {24'd0, co8, s8}, 33'(x + y + c));
        end
      end
    end
    // R8: 32-bit corners and random vectors.
    apply32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    apply32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    apply32(32'h8000_0000, 32'h8000_0000, 1'b0);
    apply32(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    for (int k = 0; k < 3000; k++) begin
      logic [W32-1:0] ra, rb;
      ra = $urandom;
      rb = (k % 4 == 0) ? ~ra : $urandom;
      apply32(ra, rb, 1'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule